// File: doc/BRIEF.md
# Dual-Port Byte-Masked Block RAM

A 4,608-bit on-chip memory with two symmetric read/write ports, A and B, organised as 256 words of 18 bits. Each word has two 9-bit bytes. Bit 8 of each byte is meant to hold parity, but the block stores it as plain data and does not generate or check it. Each port has its own address, write data, write enable, per-byte write enables, an address clock enable and a synchronous clear for its output register. Both ports are clocked by one shared clock, so an access by A and an access by B in the same cycle have a defined result.

Every access uses an effective address. When the port's address clock enable is high, that address is the address input. When it is low, the port reuses the address it held from its last access, which lets a consumer stall on the same word for as long as it needs. A write takes place at the clock edge. The read half of the same access is captured into a read register at that edge, and an optional output register adds a second stage.

Top module: `dual_port_be_ram`

## Requirements
- R1: The block holds 256 words of 18 bits. Byte i is bits [9i+8:9i], and bit 9i+8 (the parity position) is stored and returned like any other data bit. A word written through either port reads back unchanged through either port.
- R2: With OUT_REG=1 (default), read data for an access appears on the port's read output two clock edges after the access is presented. With OUT_REG=0, it appears one edge after.
- R3: A write updates only the bytes whose byte-enable bit i is 1 while the write enable is 1. The other bytes of that word keep their earlier contents.
- R4: While addr_ce is 0, the port ignores its address input, and both its reads and its writes use the effective address of its previous access.
- R5: When a port reads the word it is writing in the same cycle, its read data shows the new value on the enabled bytes and the stored value on the other bytes.
- R6: When a port reads the word that the other port is writing in the same cycle, it returns the value stored before that write.
- R7: Asserting clr zeroes the port's final output register at the next edge. Memory contents and the other pipeline stage are not affected.
- R8: While reset is active, and up to the first edge after it is released, both read outputs are zero.
- R9: When both ports write the same word in the same cycle, each byte enabled on port A takes A's data. A byte enabled only on port B takes B's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock for both ports |
| rst_ni | input | 1 | Asynchronous active-low reset of address and output registers |
| a_addr_i | input | 8 | Port A address |
| a_addr_ce_i | input | 1 | Port A address clock enable; 0 keeps the previous address |
| a_wdata_i | input | 18 | Port A write data |
| a_we_i | input | 1 | Port A write enable |
| a_be_i | input | 2 | Port A byte enables, bit i selects byte i |
| a_clr_i | input | 1 | Port A synchronous output clear |
| a_rdata_o | output | 18 | Port A read data |
| b_addr_i | input | 8 | Port B address |
| b_addr_ce_i | input | 1 | Port B address clock enable |
| b_wdata_i | input | 18 | Port B write data |
| b_we_i | input | 1 | Port B write enable |
| b_be_i | input | 2 | Port B byte enables |
| b_clr_i | input | 1 | Port B synchronous output clear |
| b_rdata_o | output | 18 | Port B read data |

## Verification
The hardest case to set up from the ports is a same-cycle collision in which both ports target one word through held addresses. Each port then sees its own new bytes, the opposite port's old bytes, and a stored result that mixes A and B byte by byte. Directed steps build this case with differing byte masks. The random phase then confines both addresses to a handful of words and drops the address clock enables often, so that held addresses, overlapping writes and clears occur together many times, all checked against a bench reference model.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_BYTES  = 2;
  localparam int unsigned DEF_BYTE_W = 9;
endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned ADDR_W = dpram_pkg::DEF_ADDR_W,
  parameter int unsigned BYTES  = dpram_pkg::DEF_BYTES,
  parameter int unsigned BYTE_W = dpram_pkg::DEF_BYTE_W,
  localparam int unsigned DATA_W = BYTES * BYTE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [BYTES-1:0]  a_mask_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [BYTES-1:0]  b_mask_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // B first so that A wins on a shared byte
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < BYTES; i++) begin
      if (b_mask_i[i]) mem_q[b_addr_i][i*BYTE_W +: BYTE_W] <= b_wdata_i[i*BYTE_W +: BYTE_W];
      if (a_mask_i[i]) mem_q[a_addr_i][i*BYTE_W +: BYTE_W] <= a_wdata_i[i*BYTE_W +: BYTE_W];
    end
  end

  assign a_rdata_o = mem_q[a_addr_i];
  assign b_rdata_o = mem_q[b_addr_i];

  for (genvar g = 0; g < BYTES; g++) begin : g_chk
    p_a_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_mask_i[g] && b_mask_i[g] && a_addr_i == b_addr_i)
      |=> mem_q[$past(a_addr_i)][g*BYTE_W +: BYTE_W] == $past(a_wdata_i[g*BYTE_W +: BYTE_W]));
    p_masked_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_mask_i != '0 && !a_mask_i[g] && !(b_mask_i[g] && b_addr_i == a_addr_i))
      |=> mem_q[$past(a_addr_i)][g*BYTE_W +: BYTE_W] == $past(a_rdata_o[g*BYTE_W +: BYTE_W]));
  end
endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
  parameter int unsigned ADDR_W  = dpram_pkg::DEF_ADDR_W,
  parameter int unsigned BYTES   = dpram_pkg::DEF_BYTES,
  parameter int unsigned BYTE_W  = dpram_pkg::DEF_BYTE_W,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_ce_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [BYTES-1:0]  wr_mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_q;
  logic              clr_rd;

  assign acc_addr_o = addr_ce_i ? addr_i : addr_q;
  assign wr_mask_o  = we_i ? be_i : '0;
  assign clr_rd     = !OUT_REG && clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= acc_addr_o;
  end

  // own-port write-through per byte
  for (genvar g = 0; g < BYTES; g++) begin : g_merge
    assign merged[g*BYTE_W +: BYTE_W] = wr_mask_o[g] ? wdata_i[g*BYTE_W +: BYTE_W]
                                                     : mem_rdata_i[g*BYTE_W +: BYTE_W];
    p_wr_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && be_i[g] && !clr_rd) |=> rd_q[g*BYTE_W +: BYTE_W] == $past(wdata_i[g*BYTE_W +: BYTE_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (clr_rd) rd_q <= '0;
    else             rd_q <= merged;
  end

  if (OUT_REG) begin : g_oreg
    logic [DATA_W-1:0] out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    out_q <= '0;
      else if (clr_i) out_q <= '0;
      else            out_q <= rd_q;
    end
    assign rdata_o = out_q;
  end else begin : g_noreg
    assign rdata_o = rd_q;
  end

  p_addr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_ce_i && $past(rst_ni)) |-> acc_addr_o == $past(acc_addr_o));
  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rdata_o == '0);
  p_reset_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> rdata_o == '0);
endmodule

// File: rtl/dual_port_be_ram.sv
module dual_port_be_ram #(
  parameter int unsigned ADDR_W  = dpram_pkg::DEF_ADDR_W,
  parameter int unsigned BYTES   = dpram_pkg::DEF_BYTES,
  parameter int unsigned BYTE_W  = dpram_pkg::DEF_BYTE_W,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned DATA_W = BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_addr_ce_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              a_we_i,
  input  logic [BYTES-1:0]  a_be_i,
  input  logic              a_clr_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_addr_ce_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic              b_we_i,
  input  logic [BYTES-1:0]  b_be_i,
  input  logic              b_clr_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic [ADDR_W-1:0] a_acc, b_acc;
  logic [BYTES-1:0]  a_mask, b_mask;
  logic [DATA_W-1:0] a_mem, b_mem;

  dpram_port #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W), .OUT_REG(OUT_REG)) u_port_a (
    .clk_i, .rst_ni,
    .addr_i(a_addr_i), .addr_ce_i(a_addr_ce_i), .wdata_i(a_wdata_i), .we_i(a_we_i),
    .be_i(a_be_i), .clr_i(a_clr_i), .mem_rdata_i(a_mem),
    .acc_addr_o(a_acc), .wr_mask_o(a_mask), .rdata_o(a_rdata_o));

  dpram_port #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W), .OUT_REG(OUT_REG)) u_port_b (
    .clk_i, .rst_ni,
    .addr_i(b_addr_i), .addr_ce_i(b_addr_ce_i), .wdata_i(b_wdata_i), .we_i(b_we_i),
    .be_i(b_be_i), .clr_i(b_clr_i), .mem_rdata_i(b_mem),
    .acc_addr_o(b_acc), .wr_mask_o(b_mask), .rdata_o(b_rdata_o));

  dpram_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk_i, .rst_ni,
    .a_addr_i(a_acc), .a_mask_i(a_mask), .a_wdata_i(a_wdata_i),
    .b_addr_i(b_acc), .b_mask_i(b_mask), .b_wdata_i(b_wdata_i),
    .a_rdata_o(a_mem), .b_rdata_o(b_mem));
endmodule

// File: tb/dual_port_be_ram_tb.sv
module dual_port_be_ram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_addr = '0, b_addr = '0;
  logic        a_ce = 1'b1, b_ce = 1'b1, a_we = 1'b0, b_we = 1'b0, a_clr = 1'b0, b_clr = 1'b0;
  logic [17:0] a_wd = '0, b_wd = '0;
  logic [1:0]  a_be = '0, b_be = '0;
  logic [17:0] a_rd, b_rd;

  int total = 0, bad = 0;
  logic [17:0] m_mem [256];
  logic [17:0] m_a1 = '0, m_b1 = '0;
  logic [7:0]  m_ha = '0, m_hb = '0;

  always #2 clk = ~clk;

  dual_port_be_ram u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_addr_i(a_addr), .a_addr_ce_i(a_ce), .a_wdata_i(a_wd), .a_we_i(a_we), .a_be_i(a_be),
    .a_clr_i(a_clr), .a_rdata_o(a_rd),
    .b_addr_i(b_addr), .b_addr_ce_i(b_ce), .b_wdata_i(b_wd), .b_we_i(b_we), .b_be_i(b_be),
    .b_clr_i(b_clr), .b_rdata_o(b_rd));

  task automatic check(input string tag, input string port, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s port %s: actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] nw, input logic [1:0] m);
    logic [17:0] r = old;
    for (int i = 0; i < 2; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  // reference model: compute from pre-edge state, then advance one edge
  task automatic step(input string tag, input bit chk);
    logic [7:0]  ea, eb;
    logic [17:0] oa, ob, xa, xb;
    logic [1:0]  ma, mb;
    ea = a_ce ? a_addr : m_ha;
    eb = b_ce ? b_addr : m_hb;
    ma = a_we ? a_be : 2'b00;
    mb = b_we ? b_be : 2'b00;
    oa = merge(m_mem[ea], a_wd, ma);
    ob = merge(m_mem[eb], b_wd, mb);
    xa = a_clr ? 18'd0 : m_a1;
    xb = b_clr ? 18'd0 : m_b1;
    m_a1 = oa; m_b1 = ob; m_ha = ea; m_hb = eb;
    m_mem[eb] = merge(m_mem[eb], b_wd, mb);
    m_mem[ea] = merge(m_mem[ea], a_wd, ma);
    @(posedge clk);
    @(negedge clk);
    if (chk) begin
      check(tag, "A", a_rd, xa);
      check(tag, "B", b_rd, xb);
    end
  endtask

  task automatic idle();
    a_we = 0; b_we = 0; a_clr = 0; b_clr = 0; a_ce = 1; b_ce = 1;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    #5;
    check("R8", "A", a_rd, 18'd0);
    check("R8", "B", b_rd, 18'd0);
    @(negedge clk); rst_n = 1'b1;
    // R8: outputs still zero just before the first post-reset edge
    check("R8", "A", a_rd, 18'd0);
    check("R8", "B", b_rd, 18'd0);

    // preload every word through A (R1 bit 8 / bit 17 included)
    for (int i = 0; i < 256; i++) begin
      a_addr = 8'(i); a_we = 1; a_be = 2'b11; a_wd = 18'(i * 1031 + 18'h20100);
      step("R1", 0);
    end
    idle(); step("R1", 0); step("R1", 0);

    // R1/R2: full word with both parity bits written on A, read on B, two-cycle latency
    a_addr = 8'd10; a_we = 1; a_be = 2'b11; a_wd = 18'h3_01FF;
    step("R1", 1); idle();
    b_addr = 8'd10; step("R2", 1); step("R2", 1); step("R1", 1);

    // R3: masked writes, byte 0 then byte 1
    a_addr = 8'd20; a_we = 1; a_be = 2'b01; a_wd = 18'h2_AA55;
    step("R3", 1);
    a_be = 2'b10; a_addr = 8'd21; a_wd = 18'h1_5A3C;
    step("R3", 1); idle();
    a_addr = 8'd20; b_addr = 8'd21; step("R3", 1); step("R3", 1); step("R3", 1);

    // R4: address held while ce low, write lands at the held address
    a_addr = 8'd30; step("R4", 1);
    a_ce = 0; a_addr = 8'd99; a_we = 1; a_be = 2'b11; a_wd = 18'h0_BEEF;
    step("R4", 1); a_we = 0; step("R4", 1); step("R4", 1);
    idle(); b_addr = 8'd30; a_addr = 8'd99; step("R4", 1); step("R4", 1); step("R4", 1);

    // R5 and R6: A writes byte 1 of word 40 while A and B both read it
    a_addr = 8'd40; b_addr = 8'd40; a_we = 1; a_be = 2'b10; a_wd = 18'h3_FFFF;
    step("R5", 1); idle(); step("R6", 1); step("R6", 1);

    // R9: collision, overlapping and disjoint byte masks, via held addresses
    a_addr = 8'd50; b_addr = 8'd50; step("R9", 1);
    a_ce = 0; b_ce = 0; a_addr = 8'd1; b_addr = 8'd2;
    a_we = 1; b_we = 1; a_be = 2'b01; b_be = 2'b11; a_wd = 18'h0_1234; b_wd = 18'h3_5678;
    step("R9", 1); a_we = 0; b_we = 0; step("R9", 1); step("R9", 1);
    a_we = 1; b_we = 1; a_be = 2'b11; b_be = 2'b10; a_wd = 18'h2_0F0F; b_wd = 18'h1_F0F0;
    step("R9", 1); idle(); a_addr = 8'd50; b_addr = 8'd50; step("R9", 1); step("R9", 1); step("R9", 1);

    // R7: clear zeroes the output, memory intact afterwards
    a_addr = 8'd10; b_addr = 8'd20; step("R7", 1); step("R7", 1);
    a_clr = 1; b_clr = 1; step("R7", 1); step("R7", 1);
    a_clr = 0; b_clr = 0; step("R7", 1); step("R7", 1); step("R7", 1);

    // random phase over a few words to force collisions
    for (int n = 0; n < 2000; n++) begin
      a_addr = 8'($urandom_range(0, 3)); b_addr = 8'($urandom_range(0, 3));
      a_ce = ($urandom_range(0, 3) != 0); b_ce = ($urandom_range(0, 3) != 0);
      a_we = $urandom_range(0, 1); b_we = $urandom_range(0, 1);
      a_be = 2'($urandom_range(0, 3)); b_be = 2'($urandom_range(0, 3));
      a_wd = 18'($urandom); b_wd = 18'($urandom);
      a_clr = ($urandom_range(0, 9) == 0); b_clr = ($urandom_range(0, 9) == 0);
      step("R9", 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule